// File: doc/BRIEF.md
# Virtually Addressed Unified Cache Controller

This block is a unified instruction and data cache that sits between a CPU request port and an external bus master port. Lines are found and tagged by virtual address. Cachable reads that hit are served without any bus traffic. Cachable read misses fetch the whole line with an incrementing burst and then return the requested word. Writes always go out to memory. A write updates the cached copy when it hits and never allocates a line.

An atomic read-then-write pair is marked by the CPU's lock input. The read half always goes to the bus, even when the word is cached, and its data is not placed in the cache. The write half behaves like any other write. The external lock output stays high from the start of the locked read until the locked write completes, so the pair cannot be split by another bus master.

Caching is active only when both the cache-enable bit and the translation-enable bit of the control register are set. A write to the cache-operations strobe invalidates every line at once. Reset turns caching off and invalidates all lines. The CPU gives every request its own cachable attribute. The CPU issues one request, a single-cycle `cpu_req` pulse taken while the controller is idle, and then waits for the one-cycle `cpu_ready` pulse before it issues the next one.

Top module: `vcache_ctrl`

## Requirements
- R1: A cachable read miss while caching is active issues four single-word bus reads at incrementing addresses, starting at the line-aligned address. The line is 16 bytes. Byte address bits [3:2] select the word, bits [9:4] select one of 64 lines, and bits [31:10] form the tag. After the fourth beat the requested word is returned and the line becomes valid.
- R2: A cachable, unlocked read that hits while caching is active returns the cached word with no bus access. `cpu_ready` rises in the cycle after acceptance.
- R3: Every write performs exactly one bus write. When the write is cachable, caching is active and the address hits, the cached word is also updated. A write miss leaves the cache contents unchanged.
- R4: A locked read (`cpu_lock`=1, `cpu_we`=0) always performs one bus read and returns the bus data, even when the address hits. It neither allocates nor alters any line.
- R5: `ext_lock` is high during the locked read transfer, stays high while the controller is idle between the two halves, and stays high during the locked write transfer. It is low again one cycle after that write completes.
- R6: A locked write is handled exactly like an ordinary write: on a hit, the cached word is updated.
- R7: A single-cycle `cop_wr` pulse invalidates all 64 lines in the cycle that follows it.
- R8: `ctl_wr` loads the control register. Bit 2 is the cache enable and bit 0 is the translation enable. Caching is active only when both bits are 1, and they may be set in one write. While caching is inactive, every read is a single bus access and nothing is allocated.
- R9: An uncachable request always makes a single bus access and never allocates or modifies a line.
- R10: After reset, `cpu_ready`, `ext_req` and `ext_lock` are low, caching is inactive and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request pulse, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_lock | input | 1 | Request belongs to an atomic read-then-write pair |
| cpu_cachable | input | 1 | Cachable attribute of the request |
| cpu_addr | input | 32 | Virtual byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| cop_wr | input | 1 | Cache-operations write strobe, invalidates all lines |
| ext_req | output | 1 | Bus transfer request, held until acknowledged |
| ext_we | output | 1 | Bus transfer is a write |
| ext_lock | output | 1 | Bus lock for the atomic pair |
| ext_addr | output | 32 | Word-aligned bus address |
| ext_wdata | output | 32 | Bus write data |
| ext_rdata | input | 32 | Bus read data, valid with ext_ack |
| ext_ack | input | 1 | Transfer completion |

## Verification
The main function is exercised with a mix of access patterns: cold misses, hits on a line just filled, write hits and write misses, a conflict miss that evicts a line sharing its index, and uncachable reads repeated at one address. The bench counts the bus reads each access causes (four, one or none), which tells a fill, a bypass and a hit apart. Where a hit and a miss could return the same data, the bench changes its memory model behind the cache so that a stale cached value exposes the difference. The locked pair, flushing, partial enable settings and reset are then tried as directed sequences.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SINGLE = 2'd1,
    ST_FILL   = 2'd2
  } vc_state_e;
endpackage

// File: rtl/vcache_tag_store.sv
module vcache_tag_store #(
  parameter int LINES = 64,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [TAG_W-1:0] lk_tag,
  output logic             lk_valid,
  output logic [LINES-1:0] valid_vec
);
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q, valid_n;

  always_comb begin
    valid_n = valid_q;
    if (flush) valid_n = '0;
    else if (set_en) valid_n[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_mem[set_idx] <= set_tag;
  end

  assign lk_tag    = tag_mem[lk_idx];
  assign lk_valid  = valid_q[lk_idx];
  assign valid_vec = valid_q;

  // R7: invalidation empties every line on the following cycle
  p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
endmodule

// File: rtl/vcache_data_store.sv
module vcache_data_store #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/vcache_ctrl.sv
module vcache_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LINES     = 64,
  parameter int WORDS     = 4,
  parameter int CTL_MMU   = 0,
  parameter int CTL_CACHE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_lock,
  input  logic              cpu_cachable,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic              cop_wr,
  output logic              ext_req,
  output logic              ext_we,
  output logic              ext_lock,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              ext_ack
);
  import vcache_pkg::*;

  localparam int BYTE_W  = $clog2(DATA_W/8);
  localparam int OFF_W   = $clog2(WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int LINE_LO = BYTE_W + OFF_W;
  localparam int TAG_LO  = LINE_LO + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LO;
  localparam int DEPTH   = LINES * WORDS;
  localparam logic [OFF_W-1:0]  LAST_BEAT = OFF_W'(WORDS-1);
  localparam logic [ADDR_W-1:0] WSTEP     = ADDR_W'(DATA_W/8);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // control register
  logic mmu_on_q, cache_bit_q, cache_on;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mmu_on_q    <= 1'b0;
      cache_bit_q <= 1'b0;
    end else if (ctl_wr) begin
      mmu_on_q    <= ctl_wdata[CTL_MMU];
      cache_bit_q <= ctl_wdata[CTL_CACHE];
    end
  end
  assign cache_on = mmu_on_q & cache_bit_q;

  // state
  vc_state_e         state_q, state_n;
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_n;
  logic [DATA_W-1:0] cur_wdata_q, cur_wdata_n;
  logic              cur_we_q, cur_we_n, cur_lock_q, cur_lock_n, cur_cach_q, cur_cach_n;
  logic [OFF_W-1:0]  beat_q, beat_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;
  logic              ready_q, ready_n, lock_q, lock_n;

  // tag and data stores
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag_in, lk_tag;
  logic              lk_valid, hit;
  logic              set_en;
  logic [LINES-1:0]  valid_vec;
  logic              ds_we;
  logic [IDX_W+OFF_W-1:0] ds_waddr, ds_raddr;
  logic [DATA_W-1:0] ds_wdata, ds_rdata;
  logic [ADDR_W-1:0] sel_addr;

  assign sel_addr  = (state_q == ST_IDLE) ? cpu_addr : cur_addr_q;
  assign lk_idx    = sel_addr[TAG_LO-1:LINE_LO];
  assign lk_tag_in = sel_addr[ADDR_W-1:TAG_LO];
  assign hit       = lk_valid && (lk_tag == lk_tag_in);
  assign ds_raddr  = cpu_addr[TAG_LO-1:BYTE_W];

  vcache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_i), .flush(cop_wr),
    .set_en(set_en), .set_idx(cur_addr_q[TAG_LO-1:LINE_LO]),
    .set_tag(cur_addr_q[ADDR_W-1:TAG_LO]),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid),
    .valid_vec(valid_vec)
  );

  vcache_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk(clk), .wr_en(ds_we), .wr_addr(ds_waddr), .wr_data(ds_wdata),
    .rd_addr(ds_raddr), .rd_data(ds_rdata)
  );

  // request classification while idle
  logic plain_rd, rd_hit, rd_fill;
  assign plain_rd = cpu_req && !cpu_we && !cpu_lock && cpu_cachable && cache_on;
  assign rd_hit   = plain_rd && hit;
  assign rd_fill  = plain_rd && !hit;

  // next-state logic
  always_comb begin
    state_n     = state_q;
    cur_addr_n  = cur_addr_q;
    cur_wdata_n = cur_wdata_q;
    cur_we_n    = cur_we_q;
    cur_lock_n  = cur_lock_q;
    cur_cach_n  = cur_cach_q;
    beat_n      = beat_q;
    rdata_n     = rdata_q;
    ready_n     = 1'b0;
    lock_n      = lock_q;
    set_en      = 1'b0;
    ds_we       = 1'b0;
    ds_waddr    = cur_addr_q[TAG_LO-1:BYTE_W];
    ds_wdata    = ext_rdata;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          cur_addr_n  = cpu_addr;
          cur_wdata_n = cpu_wdata;
          cur_we_n    = cpu_we;
          cur_lock_n  = cpu_lock;
          cur_cach_n  = cpu_cachable;
          beat_n      = '0;
          if (rd_hit) begin
            rdata_n = ds_rdata;
            ready_n = 1'b1;
          end else if (rd_fill) begin
            state_n = ST_FILL;
          end else begin
            state_n = ST_SINGLE;
          end
        end
      end
      ST_SINGLE: begin
        if (ext_ack) begin
          state_n = ST_IDLE;
          ready_n = 1'b1;
          if (!cur_we_q) rdata_n = ext_rdata;
          if (cur_we_q && cur_cach_q && cache_on && hit) begin
            ds_we    = 1'b1;
            ds_wdata = cur_wdata_q;
          end
          if (cur_lock_q) lock_n = !cur_we_q;
        end
      end
      ST_FILL: begin
        if (ext_ack) begin
          ds_we    = 1'b1;
          ds_waddr = {cur_addr_q[TAG_LO-1:LINE_LO], beat_q};
          if (beat_q == cur_addr_q[LINE_LO-1:BYTE_W]) rdata_n = ext_rdata;
          if (beat_q == LAST_BEAT) begin
            set_en  = 1'b1;
            ready_n = 1'b1;
            state_n = ST_IDLE;
          end else begin
            beat_n = beat_q + 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q     <= ST_IDLE;
      cur_addr_q  <= '0;
      cur_wdata_q <= '0;
      cur_we_q    <= 1'b0;
      cur_lock_q  <= 1'b0;
      cur_cach_q  <= 1'b0;
      beat_q      <= '0;
      rdata_q     <= '0;
      ready_q     <= 1'b0;
      lock_q      <= 1'b0;
    end else begin
      state_q     <= state_n;
      cur_addr_q  <= cur_addr_n;
      cur_wdata_q <= cur_wdata_n;
      cur_we_q    <= cur_we_n;
      cur_lock_q  <= cur_lock_n;
      cur_cach_q  <= cur_cach_n;
      beat_q      <= beat_n;
      rdata_q     <= rdata_n;
      ready_q     <= ready_n;
      lock_q      <= lock_n;
    end
  end

  // outputs
  assign cpu_rdata = rdata_q;
  assign cpu_ready = ready_q;
  assign ext_req   = (state_q != ST_IDLE);
  assign ext_we    = (state_q == ST_SINGLE) && cur_we_q;
  assign ext_wdata = cur_wdata_q;
  assign ext_lock  = lock_q || ((state_q == ST_SINGLE) && cur_lock_q);
  assign ext_addr  = (state_q == ST_FILL)
                   ? {cur_addr_q[ADDR_W-1:LINE_LO], beat_q, BYTE_W'(0)}
                   : {cur_addr_q[ADDR_W-1:BYTE_W], BYTE_W'(0)};

  logic unused_ctl;
  assign unused_ctl = ^{ctl_wdata, cpu_addr[BYTE_W-1:0]};

  // R1: fill beats advance by one word
  p_fill_incr_r1: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_FILL && ext_ack && beat_q != LAST_BEAT)
      |=> (ext_addr == $past(ext_addr) + WSTEP));

  // R2: a read hit completes next cycle with no bus request
  p_hit_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_IDLE && rd_hit) |=> (cpu_ready && !ext_req));

  // R4: a locked read always becomes a locked bus read
  p_lock_bypass_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_IDLE && cpu_req && !cpu_we && cpu_lock)
      |=> (ext_req && !ext_we && ext_lock));

  // R5: the lock survives completion of the locked read
  p_lock_held_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (ext_req && ext_ack && !ext_we && ext_lock) |=> ext_lock);

  // R9: single transfers never change line validity
  p_no_alloc_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_SINGLE && !cop_wr) |=> $stable(valid_vec));
endmodule

// File: tb/vcache_ctrl_test.sv
`timescale 1ns/1ps
module vcache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, cpu_lock, cpu_cachable;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic        ctl_wr, cop_wr;
  logic [31:0] ctl_wdata;
  logic        ext_req, ext_we, ext_lock, ext_ack;
  logic [31:0] ext_addr, ext_wdata, ext_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int n_rd     = 0;
  int n_wr     = 0;
  logic wr_lock_seen;
  logic [31:0] mem [1024];

  always #2.5 clk = ~clk;

  vcache_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_lock(cpu_lock), .cpu_cachable(cpu_cachable), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .cop_wr(cop_wr),
    .ext_req(ext_req), .ext_we(ext_we), .ext_lock(ext_lock),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ext_ack(ext_ack)
  );

  // memory model: acknowledges one cycle after a request appears
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_ack <= 1'b0;
    end else begin
      ext_ack   <= ext_req && !ext_ack;
      ext_rdata <= mem[ext_addr[11:2]];
      if (ext_req && ext_we && !ext_ack) mem[ext_addr[11:2]] <= ext_wdata;
      if (ext_req && ext_ack && !ext_we) n_rd <= n_rd + 1;
      if (ext_req && ext_ack && ext_we) begin
        n_wr <= n_wr + 1;
        wr_lock_seen <= ext_lock;
      end
    end
  end

  typedef struct packed {
    logic        we;
    logic        cach;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  nrd;
  } vec_t;

  // word i of memory starts as 32'hC000_0000 | i
  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b1, 32'h040, 32'h0,         32'hC000_0010, 4'd4}, // R1 cold miss
    '{1'b0, 1'b1, 32'h044, 32'h0,         32'hC000_0011, 4'd0}, // R2 hit
    '{1'b1, 1'b1, 32'h048, 32'h1111_2222, 32'h0,         4'd0}, // R3 write hit
    '{1'b0, 1'b1, 32'h048, 32'h0,         32'h1111_2222, 4'd0}, // R3 updated word
    '{1'b0, 1'b1, 32'h440, 32'h0,         32'hC000_0110, 4'd4}, // R1 conflict miss
    '{1'b0, 1'b1, 32'h040, 32'h0,         32'hC000_0010, 4'd4}, // R1 refill after eviction
    '{1'b0, 1'b0, 32'h080, 32'h0,         32'hC000_0020, 4'd1}, // R9 uncachable
    '{1'b0, 1'b0, 32'h080, 32'h0,         32'hC000_0020, 4'd1}, // R9 still not allocated
    '{1'b1, 1'b1, 32'h0C0, 32'h3333_4444, 32'h0,         4'd0}, // R3 write miss
    '{1'b0, 1'b1, 32'h0C0, 32'h0,         32'h3333_4444, 4'd4}  // R3 no write allocation
  };

  function automatic string row_req(int i);
    case (i)
      0, 4, 5: return "R1";
      1:       return "R2";
      6, 7:    return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic access(input logic we, input logic lk, input logic cach,
                        input logic [31:0] a, input logic [31:0] wd);
    int waited = 0;
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_lock = lk; cpu_cachable = cach;
    cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_ready && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    if (!cpu_ready) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: no cpu_ready for address %h, got 0 expected 1", a);
    end
  endtask

  task automatic ctl(input logic [31:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hC000_0000 | i;
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_lock = 0; cpu_cachable = 0;
    cpu_addr = 0; cpu_wdata = 0; ctl_wr = 0; ctl_wdata = 0; cop_wr = 0;
    repeat (3) @(negedge clk);
    check("R10", "cpu_ready in reset", {31'b0, cpu_ready}, 32'd0);
    check("R10", "ext_req in reset", {31'b0, ext_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    ctl(32'h5); // R8: both enables in one write
    for (int i = 0; i < 10; i++) begin
      access(VEC[i].we, 1'b0, VEC[i].cach, VEC[i].addr, VEC[i].wd);
      if (!VEC[i].we) check(row_req(i), $sformatf("row %0d data", i), cpu_rdata, VEC[i].exp);
      else            check(row_req(i), $sformatf("row %0d bus writes", i), n_wr, 32'd1);
      check(row_req(i), $sformatf("row %0d bus reads", i), n_rd, {28'b0, VEC[i].nrd});
    end

    // hit returns the stale cached copy after a change behind the cache
    mem[32'h044 >> 2] = 32'hDEAD_0044;
    access(1'b0, 1'b0, 1'b1, 32'h044, 0);
    check("R2", "stale hit data", cpu_rdata, 32'hC000_0011);
    check("R2", "hit bus reads", n_rd, 0);

    // locked pair
    access(1'b0, 1'b1, 1'b1, 32'h044, 0);
    check("R4", "locked read data", cpu_rdata, 32'hDEAD_0044);
    check("R4", "locked read bus reads", n_rd, 1);
    @(negedge clk);
    check("R5", "lock between halves", {31'b0, ext_lock}, 32'd1);
    access(1'b0, 1'b0, 1'b1, 32'h044, 0);
    check("R4", "line untouched by locked read", cpu_rdata, 32'hC000_0011);
    check("R4", "line still hits", n_rd, 0);
    access(1'b1, 1'b1, 1'b1, 32'h044, 32'h0000_0077);
    check("R5", "lock on write beat", {31'b0, wr_lock_seen}, 32'd1);
    @(negedge clk);
    check("R5", "lock released", {31'b0, ext_lock}, 32'd0);
    access(1'b0, 1'b0, 1'b1, 32'h044, 0);
    check("R6", "locked write updated hit", cpu_rdata, 32'h0000_0077);
    check("R6", "updated word hits", n_rd, 0);

    // flush
    @(negedge clk); cop_wr = 1'b1;
    @(negedge clk); cop_wr = 1'b0;
    access(1'b0, 1'b0, 1'b1, 32'h044, 0);
    check("R7", "read after flush refills", n_rd, 4);
    check("R7", "read after flush data", cpu_rdata, 32'h0000_0077);
    access(1'b0, 1'b0, 1'b1, 32'h0C0, 0);
    check("R7", "other line flushed too", n_rd, 4);

    // reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10", "ext_lock in reset", {31'b0, ext_lock}, 32'd0);
    check("R10", "ext_req in reset", {31'b0, ext_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b0, 1'b0, 1'b1, 32'h040, 0);
    check("R10", "disabled after reset", n_rd, 1);
    ctl(32'h4);
    access(1'b0, 1'b0, 1'b1, 32'h040, 0);
    check("R8", "cache bit alone: single read", n_rd, 1);
    access(1'b0, 1'b0, 1'b1, 32'h040, 0);
    check("R8", "cache bit alone: no allocation", n_rd, 1);
    ctl(32'h5);
    access(1'b0, 1'b0, 1'b1, 32'h040, 0);
    check("R10", "lines invalid after reset", n_rd, 4);
    access(1'b0, 1'b0, 1'b1, 32'h040, 0);
    check("R8", "enabled: hit", n_rd, 0);
    check("R8", "enabled: hit data", cpu_rdata, 32'hC000_0010);

    finish_run();
  end
endmodule